// File: doc/BRIEF.md
# Peripheral Interrupt Register Block

This block is the interrupt slice of a memory-mapped peripheral. Raw interrupt conditions from the peripheral's own logic come in on one wire per source, and one interrupt wire per source goes out toward the processor's interrupt controller. Software reaches the slice through a plain register port: address, write data, write strobe, read strobe and read data. Three word registers sit at the bottom of the address map: a pending-state register at 0x0, a mask (enable) register at 0x4 and a force (test) register at 0x8.

Each source is fixed at elaboration as either an event source or a status source. An event source latches a pending flag that software clears by writing one. A status source mirrors its hardware condition and software cannot clear it. Every event source runs a two-state machine: EVT_IDLE (nothing pending) and EVT_PEND (pending). There are two transitions. EVT_IDLE goes to EVT_PEND on a set, which is a hardware condition or a force write. EVT_PEND goes to EVT_IDLE on a clear write, but only when no set arrives in the same cycle. Every other case holds the current state. The register port decodes each access into one of four targets: ACC_STATE, ACC_ENABLE, ACC_TEST or ACC_NONE.

Top module: `irq_slice_top`

## Requirements
- R1: The pending-state register is read at byte offset 0x0. The enable register is read and written at 0x4, and source i uses bit i. The test register is written at 0x8. Register bits above the number of sources read as zero.
- R2: Each interrupt output irq_o[i] is high exactly when pending-state bit i and enable bit i are both high.
- R3: Pending-state bits show the raw condition whatever the enable setting, including when the enable bit is zero.
- R4: An event source's state bit reads 1 from the first clock edge at which its hardware input is high. It stays 1 after the input falls.
- R5: Writing 1 to an event bit at offset 0x0 clears it after the clock edge. Writing 0 to it, or writing 1 to other bits, leaves it set.
- R6: If an event source's hardware input is high in the cycle in which software clears it, the bit stays set.
- R7: A status source's state bit equals its hardware input as sampled at the previous clock edge. Writes to offset 0x0 have no effect on it.
- R8: Writing 1 to a test bit of an event source latches that source's state bit, exactly as a hardware event does.
- R9: Writing 1 to a test bit of a status source sets its state bit for the single cycle after the write. The bit then follows the hardware input again.
- R10: Reads return zero from the test register, from any offset other than 0x0 and 0x4, and whenever the read strobe is low.
- R11: An asynchronous active-low reset clears all state bits and all enable bits.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk_i | input | 1 | Clock |
| rst_ni | input | 1 | Asynchronous active-low reset |
| hw_irq_i | input | N_SRC | Raw interrupt conditions, one per source |
| reg_addr_i | input | ADDR_W | Byte address of the register access |
| reg_wdata_i | input | DATA_W | Write data |
| reg_we_i | input | 1 | Write strobe |
| reg_re_i | input | 1 | Read strobe |
| reg_rdata_o | output | DATA_W | Read data, combinational, zero when not reading |
| irq_o | output | N_SRC | Masked interrupt wires, one per source |

## Verification
Two operations can land on an event bit in the same cycle: a software write-one-to-clear and a hardware set. The bench provokes this by holding the raw input high while it writes 1 to the state register. It judges the outcome by reading the state bit after the edge, and expects it to still be set. It then drops the input and repeats the clear, and expects the bit to fall. The same collision is tried on a status bit, where the write must be ignored. A force write that arrives while the hardware input is low is also checked against the one-cycle pulse a status bit must show.

// File: rtl/irq_slice_pkg.sv
package irq_slice_pkg;

    localparam int unsigned OFF_STATE  = 32'h0;
    localparam int unsigned OFF_ENABLE = 32'h4;
    localparam int unsigned OFF_TEST   = 32'h8;

    typedef enum logic {
        EVT_IDLE = 1'b0,
        EVT_PEND = 1'b1
    } evt_st_e;

    typedef enum logic [1:0] {
        ACC_NONE   = 2'd0,
        ACC_STATE  = 2'd1,
        ACC_ENABLE = 2'd2,
        ACC_TEST   = 2'd3
    } acc_sel_e;

endpackage

// File: rtl/irq_src_cell.sv
module irq_src_cell
    import irq_slice_pkg::*;
#(
    parameter bit IS_STATUS = 1'b0
) (
    input  logic clk_i,
    input  logic rst_ni,
    input  logic hw_i,
    input  logic clr_i,
    input  logic tst_i,
    output logic state_o
);

    logic set_req;
    assign set_req = hw_i | tst_i;

    generate
        if (IS_STATUS) begin : g_status
            logic lvl_q;

            always_ff @(posedge clk_i or negedge rst_ni) begin
                if (!rst_ni) lvl_q <= 1'b0;
                else         lvl_q <= set_req;
            end

            assign state_o = lvl_q;

            // R7: the bit drops when neither condition nor force is present
            p_sts_drop_r7: assert property (@(posedge clk_i) disable iff (!rst_ni)
                (!hw_i && !tst_i) |=> !state_o);
            // R7: a software clear cannot pull a live status bit low
            p_sts_noclr_r7: assert property (@(posedge clk_i) disable iff (!rst_ni)
                (hw_i && clr_i) |=> state_o);
            // R9: a force on a status source shows in the next cycle
            p_sts_force_r9: assert property (@(posedge clk_i) disable iff (!rst_ni)
                tst_i |=> state_o);
        end else begin : g_event
            evt_st_e st_q, st_d;

            always_ff @(posedge clk_i or negedge rst_ni) begin
                if (!rst_ni) st_q <= EVT_IDLE;
                else         st_q <= st_d;
            end

            always_comb begin
                st_d = st_q;
                unique case (st_q)
                    EVT_IDLE: if (set_req) st_d = EVT_PEND;
                    EVT_PEND: if (clr_i && !set_req) st_d = EVT_IDLE;
                    default:  st_d = EVT_IDLE;
                endcase
            end

            assign state_o = (st_q == EVT_PEND);

            // R4: a hardware condition is latched at the next edge
            p_evt_latch_r4: assert property (@(posedge clk_i) disable iff (!rst_ni)
                hw_i |=> state_o);
            // R4: without a clear, a pending bit is held
            p_evt_hold_r4: assert property (@(posedge clk_i) disable iff (!rst_ni)
                (state_o && !clr_i) |=> state_o);
            // R6: a set in the clearing cycle wins
            p_evt_set_wins_r6: assert property (@(posedge clk_i) disable iff (!rst_ni)
                (clr_i && hw_i) |=> state_o);
            // R8: a force latches the event
            p_evt_force_r8: assert property (@(posedge clk_i) disable iff (!rst_ni)
                tst_i |=> state_o);
        end
    endgenerate

endmodule

// File: rtl/irq_reg_port.sv
module irq_reg_port
    import irq_slice_pkg::*;
#(
    parameter int N_SRC  = 4,
    parameter int ADDR_W = 8,
    parameter int DATA_W = 32
) (
    input  logic              clk_i,
    input  logic              rst_ni,
    input  logic [ADDR_W-1:0] addr_i,
    input  logic [DATA_W-1:0] wdata_i,
    input  logic              we_i,
    input  logic              re_i,
    input  logic [N_SRC-1:0]  state_i,
    output logic [N_SRC-1:0]  en_o,
    output logic [N_SRC-1:0]  clr_o,
    output logic [N_SRC-1:0]  tst_o,
    output logic [DATA_W-1:0] rdata_o
);

    localparam logic [ADDR_W-1:0] A_STATE  = ADDR_W'(OFF_STATE);
    localparam logic [ADDR_W-1:0] A_ENABLE = ADDR_W'(OFF_ENABLE);
    localparam logic [ADDR_W-1:0] A_TEST   = ADDR_W'(OFF_TEST);

    acc_sel_e          sel;
    logic [N_SRC-1:0]  en_q;
    logic              unused_wdata;

    assign unused_wdata = ^wdata_i;

    always_comb begin
        unique case (addr_i)
            A_STATE:  sel = ACC_STATE;
            A_ENABLE: sel = ACC_ENABLE;
            A_TEST:   sel = ACC_TEST;
            default:  sel = ACC_NONE;
        endcase
    end

    always_ff @(posedge clk_i or negedge rst_ni) begin
        if (!rst_ni)                          en_q <= '0;
        else if (we_i && sel == ACC_ENABLE)   en_q <= wdata_i[N_SRC-1:0];
    end

    assign en_o  = en_q;
    assign clr_o = (we_i && sel == ACC_STATE) ? wdata_i[N_SRC-1:0] : '0;
    assign tst_o = (we_i && sel == ACC_TEST)  ? wdata_i[N_SRC-1:0] : '0;

    always_comb begin
        rdata_o = '0;
        if (re_i) begin
            unique case (sel)
                ACC_STATE:  rdata_o[N_SRC-1:0] = state_i;
                ACC_ENABLE: rdata_o[N_SRC-1:0] = en_q;
                ACC_TEST:   rdata_o = '0;
                default:    rdata_o = '0;
            endcase
        end
    end

    // R1: an enable write is visible after the edge
    p_en_write_r1: assert property (@(posedge clk_i) disable iff (!rst_ni)
        (we_i && addr_i == A_ENABLE) |=> en_o == $past(wdata_i[N_SRC-1:0]));
    // R1: the enable register does not move without a write to it
    p_en_stable_r1: assert property (@(posedge clk_i) disable iff (!rst_ni)
        !(we_i && addr_i == A_ENABLE) |=> $stable(en_o));
    // R10: the test register reads as zero
    p_rd_test_zero_r10: assert property (@(posedge clk_i) disable iff (!rst_ni)
        (re_i && addr_i == A_TEST) |-> rdata_o == '0);
    // R10: no read strobe, no data
    p_rd_idle_zero_r10: assert property (@(posedge clk_i) disable iff (!rst_ni)
        !re_i |-> rdata_o == '0);

endmodule

// File: rtl/irq_slice_top.sv
module irq_slice_top
    import irq_slice_pkg::*;
#(
    parameter int          N_SRC       = 4,
    parameter logic [31:0] STATUS_MASK = 32'h0000_000C,
    parameter int          ADDR_W      = 8,
    parameter int          DATA_W      = 32
) (
    input  logic              clk_i,
    input  logic              rst_ni,
    input  logic [N_SRC-1:0]  hw_irq_i,
    input  logic [ADDR_W-1:0] reg_addr_i,
    input  logic [DATA_W-1:0] reg_wdata_i,
    input  logic              reg_we_i,
    input  logic              reg_re_i,
    output logic [DATA_W-1:0] reg_rdata_o,
    output logic [N_SRC-1:0]  irq_o
);

    logic [N_SRC-1:0] state_w;
    logic [N_SRC-1:0] en_w;
    logic [N_SRC-1:0] clr_w;
    logic [N_SRC-1:0] tst_w;

    irq_reg_port #(
        .N_SRC  (N_SRC),
        .ADDR_W (ADDR_W),
        .DATA_W (DATA_W)
    ) u_port (
        .clk_i   (clk_i),
        .rst_ni  (rst_ni),
        .addr_i  (reg_addr_i),
        .wdata_i (reg_wdata_i),
        .we_i    (reg_we_i),
        .re_i    (reg_re_i),
        .state_i (state_w),
        .en_o    (en_w),
        .clr_o   (clr_w),
        .tst_o   (tst_w),
        .rdata_o (reg_rdata_o)
    );

    for (genvar i = 0; i < N_SRC; i++) begin : g_src
        irq_src_cell #(
            .IS_STATUS (STATUS_MASK[i])
        ) u_cell (
            .clk_i   (clk_i),
            .rst_ni  (rst_ni),
            .hw_i    (hw_irq_i[i]),
            .clr_i   (clr_w[i]),
            .tst_i   (tst_w[i]),
            .state_o (state_w[i])
        );

        // R2: a masked source never drives its wire
        p_irq_gate_r2: assert property (@(posedge clk_i) disable iff (!rst_ni)
            !en_w[i] |-> !irq_o[i]);
    end

    assign irq_o = state_w & en_w;

endmodule

// File: tb/irq_slice_top_tb.sv
module irq_slice_top_tb;

    localparam int N = 4;
    localparam logic [N-1:0] STS = 4'b1100;
    localparam logic [N-1:0] EVT = 4'b0011;

    logic          clk = 1'b0;
    logic          rst_n = 1'b0;
    logic [N-1:0]  hw = '0;
    logic [7:0]    addr = '0;
    logic [31:0]   wdata = '0;
    logic          we = 1'b0;
    logic          re = 1'b0;
    logic [31:0]   rdata;
    logic [N-1:0]  irq;

    int n_chk = 0;
    int n_fail = 0;
    bit done = 1'b0;

    always #10 clk = ~clk;

    irq_slice_top #(
        .N_SRC       (N),
        .STATUS_MASK (32'h0000_000C),
        .ADDR_W      (8),
        .DATA_W      (32)
    ) u_dut (
        .clk_i       (clk),
        .rst_ni      (rst_n),
        .hw_irq_i    (hw),
        .reg_addr_i  (addr),
        .reg_wdata_i (wdata),
        .reg_we_i    (we),
        .reg_re_i    (re),
        .reg_rdata_o (rdata),
        .irq_o       (irq)
    );

    task automatic check(input string req, input logic [31:0] act, input logic [31:0] exp);
        n_chk++;
        if (act !== exp) begin
            n_fail++;
            $display("FAIL %s: actual %h expected %h", req, act, exp);
        end
    endtask

    task automatic tick();
        @(posedge clk);
        #1;
    endtask

    task automatic wr(input logic [7:0] a, input logic [31:0] d);
        addr = a; wdata = d; we = 1'b1;
        tick();
        we = 1'b0; wdata = '0;
    endtask

    task automatic rd(input logic [7:0] a, output logic [31:0] d);
        addr = a; re = 1'b1;
        #1;
        d = rdata;
        re = 1'b0;
        #1;
    endtask

    task automatic finish_run();
        if (!done) begin
            done = 1'b1;
            $display("End of test - %0d assertions evaluated, %0d failures", n_chk, n_fail);
            $finish;
        end
    endtask

    initial begin
        repeat (200000) @(posedge clk);
        n_chk++;
        n_fail++;
        $display("FAIL watchdog: actual timeout expected completion");
        finish_run();
    end

    initial begin
        logic [31:0] v;
        #5;
        // R11: reset state
        rd(8'h0, v); check("R11 state at reset", v, 0);
        rd(8'h4, v); check("R11 enable at reset", v, 0);
        check("R11 irq at reset", 32'(irq), 0);
        tick();
        rst_n = 1'b1;
        tick();

        // R2 R3 R4 R7 R5: sweep enable x hardware pattern
        for (int e = 0; e < 16; e++) begin
            for (int h = 0; h < 16; h++) begin
                wr(8'h4, 32'(e));
                hw = N'(h);
                tick();
                rd(8'h0, v); check("R4/R7 state after rise", v, 32'(h));
                check("R2 irq gated", 32'(irq), 32'(h & e));
                hw = '0;
                tick();
                rd(8'h0, v); check("R4/R7 state after fall", v, 32'(h & EVT));
                check("R2/R3 irq after fall", 32'(irq), 32'(h & e & EVT));
                wr(8'h0, 32'hF);
                rd(8'h0, v); check("R5 cleared", v, 0);
            end
        end

        // R3: state visible with enable zero
        wr(8'h4, 0);
        hw = 4'b0001; tick(); hw = '0;
        rd(8'h0, v); check("R3 raw state unmasked", v, 1);
        check("R3 irq off while masked", 32'(irq), 0);
        // R5: zero write and other-bit write keep it
        wr(8'h0, 0);
        rd(8'h0, v); check("R5 write zero no effect", v, 1);
        wr(8'h0, 32'h2);
        rd(8'h0, v); check("R5 other bit no effect", v, 1);
        wr(8'h0, 32'h1);
        rd(8'h0, v); check("R5 write one clears", v, 0);

        // R6: clear while hardware still high
        hw = 4'b0001; tick();
        wr(8'h0, 32'h1);
        rd(8'h0, v); check("R6 set wins over clear", v, 1);
        hw = '0;
        wr(8'h0, 32'h1);
        rd(8'h0, v); check("R6 clear after drop", v, 0);

        // R7: status ignores clear writes
        hw = 4'b0100; tick();
        wr(8'h0, 32'hF);
        rd(8'h0, v); check("R7 status ignores write", v, 32'h4);
        hw = '0; tick();
        rd(8'h0, v); check("R7 status follows drop", v, 0);

        // R8: force an event source
        wr(8'h8, 32'h2);
        rd(8'h0, v); check("R8 force latches event", v, 32'h2);
        tick();
        rd(8'h0, v); check("R8 forced event held", v, 32'h2);
        wr(8'h0, 32'h2);

        // R9: force a status source
        wr(8'h4, 32'hF);
        wr(8'h8, 32'h8);
        rd(8'h0, v); check("R9 status forced one cycle", v, 32'h8);
        check("R9 irq during force", 32'(irq), 32'h8);
        tick();
        rd(8'h0, v); check("R9 status force ends", v, 0);

        // R10: test reg and unmapped reads
        rd(8'h8, v); check("R10 test reads zero", v, 0);
        hw = 4'b0001; tick(); hw = '0;
        rd(8'h4, v); check("R1 enable readback", v, 32'hF);
        rd(8'h0, v); check("R1 state readback", v, 1);
        rd(8'hC, v); check("R10 unmapped 0xC", v, 0);
        rd(8'h1, v); check("R10 unmapped 0x1", v, 0);
        rd(8'h10, v); check("R10 unmapped 0x10", v, 0);
        addr = 8'h0; #1; check("R10 no strobe zero", rdata, 0);
        wr(8'h4, 32'hFFFF_FFF5);
        rd(8'h4, v); check("R1 enable upper bits zero", v, 32'h5);

        // R11: asynchronous reset mid-run
        #3 rst_n = 1'b0; #1;
        rd(8'h0, v); check("R11 state cleared", v, 0);
        rd(8'h4, v); check("R11 enable cleared", v, 0);
        check("R11 irq cleared", 32'(irq), 0);
        tick();
        finish_run();
    end

endmodule